// File: doc/BRIEF.md
# Exponential Backoff Retry Controller

This block paces the retries of one requester that keeps losing a contended atomic operation, such as a compare-and-swap. It holds a backoff count that begins at one. Each time the requester reports a failed attempt, the block issues a single request to an external pause unit. The request carries a stall length equal to the count multiplied by 128 cycles. The block then waits for the pause unit to report completion. After that, it doubles the count so that the next failure stalls twice as long.

Doubling is decided after each stall by comparing the count with a fixed limit, 4096 by default. A count above the limit stays as it is, and any other count doubles. With this order of operations the count reaches 8192, one step past the limit, and then stays there.

The requester pulses a start strobe when it begins a new atomic operation and a success strobe when an attempt finally succeeds. Either strobe returns the count to one and aborts any stall in progress. The atomic operation itself and memory coherence lie outside this block.

Top module: `backoff_retry_ctrl`

## Requirements
- R1: After reset `busy_o` and `pause_req_o` are low and `pause_amt_o` equals 128, which is a count of 1.
- R2: A `fail_i` pulse while idle raises `pause_req_o` on the next cycle. `busy_o` then stays high until `pause_done_i` is seen, and `pause_done_i` is honoured only from the cycle after `pause_req_o`.
- R3: Each failure produces exactly one `pause_req_o` pulse, one cycle long. While that pulse is high, `pause_amt_o` holds the whole stall, which is the count shifted left by 7 bits.
- R4: When a stall completes and the count is at most 4096, the count doubles. `pause_amt_o` doubles in the cycle after `pause_done_i`.
- R5: When a stall completes and the count is above 4096, the count is left unchanged. The counts therefore run 1, 2, 4 and so on up to 4096, then 8192, and stay at 8192.
- R6: A `fail_i` pulse while `busy_o` is high is ignored. It produces no request, and neither the count nor the stall in progress changes.
- R7: `success_i` returns the block to idle on the next cycle and sets the count to 1, including during a stall.
- R8: `start_i` returns the block to idle on the next cycle and sets the count to 1.
- R9: `pause_done_i` while idle has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | New atomic operation begins; count to 1 |
| fail_i | input | 1 | Attempt failed; request a stall |
| success_i | input | 1 | Attempt succeeded; idle and count to 1 |
| pause_req_o | output | 1 | One-cycle stall request to the pause unit |
| pause_amt_o | output | 21 | Stall length in cycles, the count times 128 |
| pause_done_i | input | 1 | Pause unit reports that the stall has finished |
| busy_o | output | 1 | Waiting on the pause unit |

## Verification
The bench builds the block with its default parameters: a 14-bit count, a limit of 4096 and a 7-bit scale shift. With these values the whole doubling sequence, including the step past the limit to 8192 and the saturation that follows, is reached within sixteen failures. A table walk covers this sequence. Directed tests then abort a stall with `success_i` and `start_i`, pulse `fail_i` while busy, and pulse `pause_done_i` while idle.

// File: rtl/backoff_pkg.sv
package backoff_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } bo_state_e;
endpackage

// File: rtl/backoff_count.sv
module backoff_count #(
   parameter int CNT_W    = 14,
   parameter int LIMIT    = 4096,
   parameter int SCALE_SH = 7,
   localparam int AMT_W   = CNT_W + SCALE_SH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   output logic [AMT_W-1:0] amt_o
);
   localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);
   localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i)
         cnt_q <= ONE_C;
      else if (step_i)
         cnt_q <= (cnt_q > LIM_C) ? cnt_q : (cnt_q << 1);
   end

   generate
      if (SCALE_SH == 0) begin : g_noscale
         assign amt_o = cnt_q;
      end else begin : g_scale
         assign amt_o = {cnt_q, {SCALE_SH{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/backoff_fsm.sv
module backoff_fsm
   import backoff_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic fail_i,
   input  logic success_i,
   input  logic pause_done_i,
   output logic pause_req_o,
   output logic busy_o,
   output logic clear_o,
   output logic step_o
);
   bo_state_e state_q;
   logic      abort;

   assign abort = start_i | success_i;

   always_ff @(posedge clk) begin
      if (!rst_n || abort) begin
         state_q <= ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE:  if (fail_i) state_q <= ST_ISSUE;
            ST_ISSUE: state_q <= ST_WAIT;
            ST_WAIT:  if (pause_done_i) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign pause_req_o = (state_q == ST_ISSUE);
   assign busy_o      = (state_q != ST_IDLE);
   assign clear_o     = abort;
   assign step_o      = (state_q == ST_WAIT) && pause_done_i && !abort;
endmodule

// File: rtl/backoff_retry_ctrl.sv
module backoff_retry_ctrl #(
   parameter int CNT_W    = 14,
   parameter int LIMIT    = 4096,
   parameter int SCALE_SH = 7,
   localparam int AMT_W   = CNT_W + SCALE_SH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             fail_i,
   input  logic             success_i,
   output logic             pause_req_o,
   output logic [AMT_W-1:0] pause_amt_o,
   input  logic             pause_done_i,
   output logic             busy_o
);
   generate
      if (CNT_W < 2 || LIMIT < 1 || SCALE_SH < 0)
         $error("backoff_retry_ctrl: bad parameter values");
      if (longint'(2) * LIMIT >= (longint'(1) << CNT_W))
         $error("backoff_retry_ctrl: CNT_W cannot hold the saturated count");
   endgenerate

   logic clear_w;
   logic step_w;

   backoff_fsm fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .fail_i      (fail_i),
      .success_i   (success_i),
      .pause_done_i(pause_done_i),
      .pause_req_o (pause_req_o),
      .busy_o      (busy_o),
      .clear_o     (clear_w),
      .step_o      (step_w)
   );

   backoff_count #(
      .CNT_W   (CNT_W),
      .LIMIT   (LIMIT),
      .SCALE_SH(SCALE_SH)
   ) cnt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(clear_w),
      .step_i (step_w),
      .amt_o  (pause_amt_o)
   );
endmodule

// File: rtl/backoff_retry_chk.sv
module backoff_retry_chk #(
   parameter int AMT_W    = 21,
   parameter int LIMIT    = 4096,
   parameter int SCALE_SH = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             fail_i,
   input logic             success_i,
   input logic             pause_req_o,
   input logic [AMT_W-1:0] pause_amt_o,
   input logic             pause_done_i,
   input logic             busy_o
);
   localparam logic [AMT_W-1:0] LIM_AMT = AMT_W'(longint'(LIMIT) << SCALE_SH);
   localparam logic [AMT_W-1:0] ONE_AMT = AMT_W'(longint'(1) << SCALE_SH);

   logic quiet;
   assign quiet = !start_i && !success_i;

   assert_req_after_fail_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_i && !busy_o && quiet) |=> (pause_req_o && busy_o));

   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pause_req_o |=> !pause_req_o);

   assert_double_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !pause_req_o && pause_done_i && quiet && pause_amt_o <= LIM_AMT)
      |=> (pause_amt_o == ($past(pause_amt_o) << 1)));

   assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !pause_req_o && pause_done_i && quiet && pause_amt_o > LIM_AMT)
      |=> $stable(pause_amt_o));

   assert_fail_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !pause_done_i && quiet) |=> ($stable(pause_amt_o) && busy_o));

   assert_success_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      success_i |=> (!busy_o && pause_amt_o == ONE_AMT));

   assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!busy_o && pause_amt_o == ONE_AMT));
endmodule

bind backoff_retry_ctrl backoff_retry_chk #(
   .AMT_W   (AMT_W),
   .LIMIT   (LIMIT),
   .SCALE_SH(SCALE_SH)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .fail_i      (fail_i),
   .success_i   (success_i),
   .pause_req_o (pause_req_o),
   .pause_amt_o (pause_amt_o),
   .pause_done_i(pause_done_i),
   .busy_o      (busy_o)
);

// File: tb/backoff_retry_ctrl_tb_top.sv
module backoff_retry_ctrl_tb_top;
   localparam int AW = 21;
   localparam int NV = 16;
   // expected stall length requested by failure k (count x 128)
   localparam logic [AW-1:0] EXP_AMT [NV] = '{
      21'd128,    21'd256,    21'd512,     21'd1024,
      21'd2048,   21'd4096,   21'd8192,    21'd16384,
      21'd32768,  21'd65536,  21'd131072,  21'd262144,
      21'd524288, 21'd1048576, 21'd1048576, 21'd1048576};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0, fail_i = 1'b0, success_i = 1'b0, pause_done_i = 1'b0;
   logic          pause_req_o, busy_o;
   logic [AW-1:0] pause_amt_o;
   int            checks = 0, errors = 0;
   bit            finished = 1'b0;

   always #5 clk = ~clk;

   backoff_retry_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .fail_i(fail_i),
      .success_i(success_i), .pause_req_o(pause_req_o), .pause_amt_o(pause_amt_o),
      .pause_done_i(pause_done_i), .busy_o(busy_o));

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one failure: request, wait two cycles, then done
   task automatic one_fail(input string req, input logic [AW-1:0] exp_amt);
      fail_i = 1'b1;
      @(negedge clk); fail_i = 1'b0;
      chk({req, " req pulse"}, pause_req_o, 1);
      chk({req, " amount"}, pause_amt_o, exp_amt);
      @(negedge clk);
      chk({req, " req drops"}, pause_req_o, 0);
      chk({req, " busy"}, busy_o, 1);
      @(negedge clk); pause_done_i = 1'b1;
      @(negedge clk); pause_done_i = 1'b0;
      chk({req, " idle after done"}, busy_o, 0);
   endtask

   task automatic pulse_start();
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy", busy_o, 0);
      chk("R1 req", pause_req_o, 0);
      chk("R1 amount", pause_amt_o, 128);

      // R4 R5: doubling sequence and saturation, walked from the table
      for (int k = 0; k < NV; k++) begin
         one_fail((k < 13) ? "R4" : "R5", EXP_AMT[k]);
         chk("R3 R4 R5 next amount", pause_amt_o, (k + 1 < NV) ? EXP_AMT[k + 1] : EXP_AMT[NV - 1]);
      end

      // R8: start returns count to 1
      pulse_start();
      chk("R8 amount", pause_amt_o, 128);
      chk("R8 busy", busy_o, 0);

      // R6: fail during stall ignored
      one_fail("R2", 128);
      fail_i = 1'b1;
      @(negedge clk); fail_i = 1'b0;
      chk("R2 req", pause_req_o, 1);
      fail_i = 1'b1;
      @(negedge clk); fail_i = 1'b0;
      chk("R6 no req", pause_req_o, 0);
      chk("R6 amount", pause_amt_o, 256);
      @(negedge clk);
      chk("R6 no req late", pause_req_o, 0);
      chk("R6 still busy", busy_o, 1);
      pause_done_i = 1'b1; @(negedge clk); pause_done_i = 1'b0;
      chk("R6 single doubling", pause_amt_o, 512);
      chk("R6 idle", busy_o, 0);

      // R9: done while idle has no effect
      pause_done_i = 1'b1; @(negedge clk); pause_done_i = 1'b0;
      @(negedge clk);
      chk("R9 amount", pause_amt_o, 512);
      chk("R9 busy", busy_o, 0);

      // R7: success aborts stall
      fail_i = 1'b1; @(negedge clk); fail_i = 1'b0;
      @(negedge clk);
      chk("R7 busy before", busy_o, 1);
      success_i = 1'b1; @(negedge clk); success_i = 1'b0;
      chk("R7 idle", busy_o, 0);
      chk("R7 amount", pause_amt_o, 128);

      // R8: start aborts stall
      one_fail("R8 pre", 128);
      fail_i = 1'b1; @(negedge clk); fail_i = 1'b0;
      pulse_start();
      chk("R8 abort idle", busy_o, 0);
      chk("R8 abort amount", pause_amt_o, 128);
      @(negedge clk);
      chk("R8 no req", pause_req_o, 0);

      // R1: reset mid-stall
      one_fail("R1 pre", 128);
      fail_i = 1'b1; @(negedge clk); fail_i = 1'b0;
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      chk("R1 reset busy", busy_o, 0);
      chk("R1 reset amount", pause_amt_o, 128);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule